// File: doc/BRIEF.md
# Bit-Serial Transmit Framer with Underrun Detection

The block takes bytes from a show-ahead transmit buffer and sends them as flag-delimited frames on a single serial line, one bit for each pulse of a bit-clock enable. Every frame starts with a fixed 16-bit preamble. A start flag follows, then the data with zero insertion, then a closing flag after the byte that carries the end-of-frame tag. While the block is enabled and the buffer is empty between frames, it sends flags back to back.

If the buffer runs dry before the tagged last byte has gone out, the frame is cut short. The block sends a run of ones as an abort, returns to flag fill and sets a sticky underrun bit that raises an interrupt. Software clears that bit by writing a one to it. When data arrives again, a new frame starts with its own preamble and start flag. A service request tells a DMA engine or the CPU that the buffer has room.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset the serial output is high, the interrupt is low, the status readback is 0 and no buffer read is issued.
- R2: While enabled and the buffer is empty, the output carries flag 0x7E continuously, least significant bit first, and the underrun bit stays clear.
- R3: When data is available at a unit boundary, the block sends the 16-bit preamble (LSB first), then a flag, then each byte LSB first, then a closing flag after the byte whose last tag was set.
- R4: Within the data field a 0 is inserted after every five consecutive ones, counted across byte boundaries. No insertion happens inside the preamble or the flags.
- R5: If the buffer is empty when the next data byte is due (last tag not yet seen), the block sends eight ones and then resumes flags. It also sets status bit 0 (underrun), which drives the interrupt high.
- R6: After an underrun, newly available data starts a complete new frame: preamble, start flag, data, closing flag.
- R7: Status bit 0 is cleared by writing 1 to bit 0 and is unchanged by writes of 0. Writes to bits 7..1 are ignored, and those bits always read 0.
- R8: The service request equals enable AND NOT buffer-full.
- R9: While disabled the output stays high and no byte is read, even when data is available.
- R10: Exactly one bit is emitted per bit-clock enable pulse, and a byte is read from the buffer only while the buffer reports valid data, once per byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Transmitter enable |
| bit_en | input | 1 | Bit-clock enable, one pulse per serial bit |
| buf_valid | input | 1 | Buffer holds at least one byte |
| buf_data | input | 8 | Byte at the head of the buffer |
| buf_last | input | 1 | Head byte ends its frame |
| buf_full | input | 1 | Buffer is full |
| buf_pop | output | 1 | Consume the head byte this cycle |
| tx_bit | output | 1 | Serial data output |
| svc_req | output | 1 | Buffer needs refilling |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 8 | Status write data (bit 0 clears underrun) |
| st_rdata | output | 8 | Status readback (bit 0 underrun, others zero) |
| irq | output | 1 | Interrupt request (underrun pending) |

## Verification
The state that matters is the current unit type, the bit count left in that unit and the run-of-ones counter. An error in any of them shows on the serial line no later than the next unit boundary, which is at most 16 bit pulses away. It appears as a shifted flag, a missing or extra stuffed zero, or a preamble in the wrong place. The bench therefore compares the whole serial stream bit by bit against a model built from the requirements, for idle fill, a full frame and an aborted frame. It checks the buffer read count and the underrun bit at each frame end, so an error in the pop or underrun logic shows within one frame.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int PRE_BITS = 16,
  parameter logic [PRE_BITS-1:0] PREAMBLE = 16'hA55A,
  parameter int ABORT_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       bit_en,
  input  logic       buf_valid,
  input  logic [7:0] buf_data,
  input  logic       buf_last,
  input  logic       buf_full,
  output logic       buf_pop,
  output logic       tx_bit,
  output logic       svc_req,
  input  logic       st_wr,
  input  logic [7:0] st_wdata,
  output logic [7:0] st_rdata,
  output logic       irq
);
  localparam int MAXU = (PRE_BITS > ABORT_BITS) ? PRE_BITS : ABORT_BITS;
  localparam int SW = (MAXU > 8) ? MAXU : 8;
  localparam int LW = $clog2(SW + 1);
  localparam logic [7:0] FLAG = 8'h7E;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SFLAG, S_DATA, S_EFLAG, S_ABORT} st_t;

  st_t           state, n_state;
  logic [SW-1:0] sh, n_sh, w;
  logic [LW-1:0] left, n_len, wl;
  logic [2:0]    ones;
  logic          eof, urun, stuff, ld, pop, urun_set;
  logic          unused_rsvd;

  assign stuff = (state == S_DATA) && (ones == 3'd5);
  assign ld    = (left == '0) && !stuff;

  always_comb begin
    n_state  = state;
    n_sh     = sh;
    n_len    = left;
    pop      = 1'b0;
    urun_set = 1'b0;
    if (ld) begin
      unique case (state)
        S_PRE: begin
          n_state = S_SFLAG; n_sh = SW'(FLAG); n_len = LW'(8);
        end
        S_SFLAG, S_DATA: begin
          if (state == S_DATA && eof) begin
            n_state = S_EFLAG; n_sh = SW'(FLAG); n_len = LW'(8);
          end else if (buf_valid) begin
            n_state = S_DATA; n_sh = SW'(buf_data); n_len = LW'(8); pop = 1'b1;
          end else begin
            n_state = S_ABORT; n_sh = '1; n_len = LW'(ABORT_BITS); urun_set = 1'b1;
          end
        end
        default: begin
          if (buf_valid) begin
            n_state = S_PRE; n_sh = SW'(PREAMBLE); n_len = LW'(PRE_BITS);
          end else begin
            n_state = S_IDLE; n_sh = SW'(FLAG); n_len = LW'(8);
          end
        end
      endcase
    end
  end

  assign w  = ld ? n_sh : sh;
  assign wl = ld ? n_len : left;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state  <= S_IDLE;
      sh     <= '0;
      left   <= '0;
      ones   <= '0;
      eof    <= 1'b0;
      tx_bit <= 1'b1;
    end else if (bit_en) begin
      if (stuff) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else begin
        tx_bit <= w[0];
        sh     <= w >> 1;
        left   <= wl - 1'b1;
        state  <= n_state;
        if (pop) eof <= buf_last;
        ones   <= (n_state == S_DATA && w[0]) ? ones + 3'd1 : 3'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) urun <= 1'b0;
    else if (en && bit_en && urun_set) urun <= 1'b1;
    else if (st_wr && st_wdata[0]) urun <= 1'b0;
  end

  assign buf_pop     = en && bit_en && pop;
  assign svc_req     = en && !buf_full;
  assign st_rdata    = {7'b0, urun};
  assign irq         = urun;
  assign unused_rsvd = ^st_wdata[7:1];

  a_r4_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bit_en && state == S_DATA && ones == 3'd5) |=> !tx_bit);
  a_r10_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> buf_valid);
  a_r2_idle_no_urun: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bit_en && ld && state == S_IDLE) |=> !$rose(urun));
  a_r5_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (urun && !(st_wr && st_wdata[0])) |=> urun);
  a_r8_svc_full: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !svc_req);
  a_r9_off_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tx_bit);
endmodule

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
  localparam int PERIOD = 10;
  localparam logic [15:0] PRE = 16'hA55A;

  logic clk = 0, rst_n = 0, en = 0, bit_en = 0, buf_full = 0, st_wr = 0;
  logic [7:0] st_wdata = 0;
  logic buf_valid, buf_last, buf_pop, tx_bit, svc_req, irq;
  logic [7:0] buf_data, st_rdata;
  logic [7:0] bdat [16];
  logic       blast [16];
  int wr_i = 0, rd_i = 0, checks = 0, fails = 0, mones = 0;
  bit exp_q [$];

  always #(PERIOD/2) clk = ~clk;
  assign buf_valid = rd_i < wr_i;
  assign buf_data  = bdat[rd_i[3:0]];
  assign buf_last  = blast[rd_i[3:0]];
  always @(posedge clk) if (buf_pop) rd_i <= rd_i + 1;

  hdlc_tx_framer u0 (.clk, .rst_n, .en, .bit_en, .buf_valid, .buf_data, .buf_last,
    .buf_full, .buf_pop, .tx_bit, .svc_req, .st_wr, .st_wdata, .st_rdata, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(logic [7:0] d, logic l);
    bdat[wr_i[3:0]] = d; blast[wr_i[3:0]] = l; wr_i++;
  endtask

  function automatic void add(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v[i]);
  endfunction

  function automatic void add_data(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(b[i]);
      mones = b[i] ? mones + 1 : 0;
      if (mones == 5) begin exp_q.push_back(1'b0); mones = 0; end
    end
  endfunction

  task automatic step(output logic b);
    @(negedge clk) bit_en = 1;
    @(negedge clk) bit_en = 0;
    b = tx_bit;
  endtask

  task automatic run_stream(string req);
    logic b;
    int bad = -1;
    logic got = 0, want = 0;
    for (int i = 0; i < exp_q.size(); i++) begin
      step(b);
      if (b !== exp_q[i] && bad < 0) begin bad = i; got = b; want = exp_q[i]; end
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s stream bit %0d actual=%0b expected=%0b", req, bad, got, want);
    end
    exp_q.delete();
  endtask

  task automatic st_write(logic [7:0] d);
    @(negedge clk) begin st_wr = 1; st_wdata = d; end
    @(negedge clk) st_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 tx_bit", tx_bit, 1); chk("R1 irq", irq, 0);
    chk("R1 status", st_rdata, 0); chk("R1 pop", buf_pop, 0);
  endtask

  task automatic t_disabled;
    push(8'h11, 1);
    add(16'hFFFF, 8);
    run_stream("R9 line high while disabled");
    chk("R9 no read while disabled", rd_i, 0);
    chk("R8 svc low while disabled", svc_req, 0);
    wr_i = rd_i;
  endtask

  task automatic t_svc;
    @(negedge clk) en = 1;
    #1 chk("R8 svc when not full", svc_req, 1);
    @(negedge clk) buf_full = 1;
    #1 chk("R8 svc off when full", svc_req, 0);
    @(negedge clk) buf_full = 0;
  endtask

  task automatic t_idle;
    add(16'h7E, 8); add(16'h7E, 8); add(16'h7E, 8);
    run_stream("R2 idle flags");
    chk("R2 no underrun in idle", irq, 0);
  endtask

  task automatic t_frame;
    int r0 = rd_i;
    push(8'hF8, 0); push(8'h03, 0); push(8'h7E, 1);
    add(PRE, 16); add(16'h7E, 8); mones = 0;
    add_data(8'hF8); add_data(8'h03); add_data(8'h7E);
    add(16'h7E, 8);
    run_stream("R3 R4 frame with stuffing");
    chk("R10 three bytes read", rd_i - r0, 3);
    chk("R3 no underrun", irq, 0);
  endtask

  task automatic t_underrun;
    push(8'h55, 0);
    add(PRE, 16); add(16'h7E, 8); mones = 0; add_data(8'h55);
    add(16'hFFFF, 8); add(16'h7E, 8);
    run_stream("R5 abort then flags");
    chk("R5 status bit0", st_rdata, 8'h01);
    chk("R5 irq", irq, 1);
  endtask

  task automatic t_w1c;
    st_write(8'hFE);
    chk("R7 reserved write ignored", st_rdata, 8'h01);
    st_write(8'h01);
    chk("R7 write one clears", st_rdata, 8'h00);
    chk("R7 irq cleared", irq, 0);
  endtask

  task automatic t_resume;
    int r0 = rd_i;
    push(8'h81, 1);
    add(PRE, 16); add(16'h7E, 8); mones = 0; add_data(8'h81); add(16'h7E, 8);
    run_stream("R6 new frame after underrun");
    chk("R10 one byte read", rd_i - r0, 1);
    chk("R6 no new underrun", irq, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_svc();
    t_idle();
    t_frame();
    t_underrun();
    t_w1c();
    t_resume();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule